// File: doc/BRIEF.md
# Watermark Pause Request Generator

This block watches the occupancy of a receive buffer and, when the buffer is close to full, asks the transmit path to send a MAC control pause frame to the link partner. A fill level at or above a programmable high mark produces a pause frame with a programmable pause time (XOFF). While the link stays paused, the block sends that frame again at a programmable interval, so the partner's pause timer does not run out. When the fill level drops below a separate low mark, the block sends a frame with a zero pause time (XON), which releases the partner.

Each request becomes a 60-byte frame, without FCS, sent one byte per accepted transfer over a valid/ready handshake. The transmit MAC adds the FCS and arbitrates between this stream and normal traffic. Whether this station obeys pause frames it receives is decided elsewhere. Generation here is governed only by its own enable, which allows asymmetric flow control.

Top module: `pause_gen`

## Requirements
- R1: After reset `tx_valid` is low and the block is in the not-paused state.
- R2: When `gen_en` is high, the block is not paused and `fill_lvl >= hi_mark`, an XOFF request is raised once and the block enters the paused state. Its frame carries `pause_time`.
- R3: Every frame is 60 bytes with `tx_last` high on the last byte only. Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are `station_mac`, most significant byte first. Bytes 12-13 are 88 08 and bytes 14-15 are 00 01. Bytes 16-17 hold the pause time, most significant byte first. Bytes 18-59 are zero.
- R4: While paused, `fill_lvl < lo_mark` raises one XON request (pause time zero) and leaves the paused state. When the block is not paused, a low level raises nothing.
- R5: A level at or above `lo_mark` and below `hi_mark` raises no request in either state.
- R6: While paused with `refresh_thr` non-zero, a new XOFF frame starts `refresh_thr*SLOT_CYCLES+2` cycles after the previous XOFF frame started. A `refresh_thr` of zero disables resends.
- R7: `tx_valid` and the byte presented stay unchanged until `tx_ready` accepts the byte.
- R8: A request that arrives while a frame is in flight waits and is sent after that frame. A newer request of the other kind replaces a pending one.
- R9: With `gen_en` low, no new request is raised, whatever the fill level.
- R10: The pause time is sampled when a frame starts, so a change to `pause_time` appears in the next XOFF frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Enables pause frame generation |
| fill_lvl | input | LVL_W | Receive buffer occupancy |
| hi_mark | input | LVL_W | Level that triggers XOFF |
| lo_mark | input | LVL_W | Level below which XON is sent |
| pause_time | input | 16 | Pause time for XOFF frames, in slot times |
| refresh_thr | input | 16 | Slot times between XOFF resends, 0 = off |
| station_mac | input | 48 | Source address of generated frames |
| tx_valid | output | 1 | Frame byte is valid |
| tx_ready | input | 1 | Transmit path accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Marks the final byte of a frame |

## Verification
A wrong paused flag shows up as a missing or extra frame at the next crossing of a mark: an XOFF while already paused, or an XON that never follows a drain. A faulty pending register loses or reorders frames, which the bench sees once the stalled frame is released. A byte-index or prescaler fault corrupts a frame field within the same frame, or moves the refresh frame away from its exact cycle. The sweep over several addresses and pause times, with and without stalls, compares every byte of every frame.

// File: rtl/pause_gen.sv
module pause_gen #(
  parameter int LVL_W       = 13,
  parameter int SLOT_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic [LVL_W-1:0] hi_mark,
  input  logic [LVL_W-1:0] lo_mark,
  input  logic [15:0]      pause_time,
  input  logic [15:0]      refresh_thr,
  input  logic [47:0]      station_mac,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last
);
  localparam int FRAME_BYTES = 60;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int PRE_W       = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [1:0] P_NONE = 2'd0, P_XOFF = 2'd1, P_XON = 2'd2;

  logic             paused_q, busy_q;
  logic [1:0]       pend_q, pend_n;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      ftime_q, slots_q;
  logic [PRE_W-1:0] pre_q;

  wire hit_hi   = fill_lvl >= hi_mark;
  wire under_lo = fill_lvl < lo_mark;
  wire req_xoff = gen_en && !paused_q && hit_hi;
  wire req_xon  = gen_en && paused_q && under_lo;
  wire req_ref  = gen_en && paused_q && !under_lo && (refresh_thr != 16'd0)
                  && (slots_q >= refresh_thr) && !busy_q && (pend_q == P_NONE);
  wire launch   = !busy_q && (pend_q != P_NONE);
  wire accept   = busy_q && tx_ready;
  wire at_end   = idx_q == IDX_W'(FRAME_BYTES - 1);
  wire slot_tick = pre_q == PRE_W'(SLOT_CYCLES - 1);

  assign tx_valid = busy_q;
  assign tx_last  = busy_q && at_end;

  always_comb begin
    pend_n = pend_q;
    if (launch) pend_n = P_NONE;
    if (req_xoff || req_ref) pend_n = P_XOFF;
    if (req_xon) pend_n = P_XON;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      busy_q   <= 1'b0;
      pend_q   <= P_NONE;
      idx_q    <= '0;
      ftime_q  <= '0;
      slots_q  <= '0;
      pre_q    <= '0;
    end else begin
      pend_q <= pend_n;
      if (req_xoff) paused_q <= 1'b1;
      else if (req_xon) paused_q <= 1'b0;

      if (launch) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        ftime_q <= (pend_q == P_XOFF) ? pause_time : 16'd0;
      end else if (accept) begin
        if (at_end) busy_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end

      if (launch && pend_q == P_XOFF) begin
        slots_q <= '0;
        pre_q   <= '0;
      end else begin
        pre_q <= slot_tick ? '0 : pre_q + 1'b1;
        if (slot_tick && slots_q != 16'hFFFF) slots_q <= slots_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (idx_q)
      6'd0:  tx_data = 8'h01;
      6'd1:  tx_data = 8'h80;
      6'd2:  tx_data = 8'hC2;
      6'd5:  tx_data = 8'h01;
      6'd6:  tx_data = station_mac[47:40];
      6'd7:  tx_data = station_mac[39:32];
      6'd8:  tx_data = station_mac[31:24];
      6'd9:  tx_data = station_mac[23:16];
      6'd10: tx_data = station_mac[15:8];
      6'd11: tx_data = station_mac[7:0];
      6'd12: tx_data = 8'h88;
      6'd13: tx_data = 8'h08;
      6'd15: tx_data = 8'h01;
      6'd16: tx_data = ftime_q[15:8];
      6'd17: tx_data = ftime_q[7:0];
      default: tx_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/pause_gen_chk.sv
module pause_gen_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             busy,
  input logic             paused,
  input logic [1:0]       pend,
  input logic [IDX_W-1:0] idx
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(idx)));

  assert_last_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_valid && tx_data == 8'h00));

  assert_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (tx_data == 8'h01));

  assert_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && pend == 2'd0) |=> (pend == 2'd0));

  assert_xon_unpaused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 2'd2) |-> !paused);

  assert_xoff_paused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 2'd1) |-> paused);

  assert_pending_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != 2'd0 && !busy) |=> tx_valid);
endmodule

bind pause_gen pause_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .busy(busy_q), .paused(paused_q), .pend(pend_q), .idx(idx_q)
);

// File: tb/pause_gen_bench.sv
module pause_gen_bench;
  localparam int S = 4;
  logic clk = 0, rst_n = 0, gen_en = 0, tx_ready = 1;
  logic [12:0] fill_lvl = 0, hi_mark = 100, lo_mark = 40;
  logic [15:0] pause_time = 16'h1234, refresh_thr = 0;
  logic [47:0] station_mac = 48'h0A1B2C3D4E5F;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;
  int total = 0, bad = 0, cyc = 0, t_seen = 0;

  pause_gen #(.LVL_W(13), .SLOT_CYCLES(S)) u_pause_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fill_lvl(fill_lvl),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .pause_time(pause_time),
    .refresh_thr(refresh_thr), .station_mac(station_mac),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] exp_byte(int i, logic [47:0] mac, logic [15:0] t);
    if (i < 6) return (i == 1) ? 8'h80 : (i == 2) ? 8'hC2 : (i == 0 || i == 5) ? 8'h01 : 8'h00;
    if (i < 12) return mac[8*(11-i) +: 8];
    if (i == 12) return 8'h88;
    if (i == 13) return 8'h08;
    if (i == 15) return 8'h01;
    if (i == 16) return t[15:8];
    if (i == 17) return t[7:0];
    return 8'h00;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic quiet(int n, string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_valid) seen = 1;
    end
    check(!seen, req, "unexpected frame", seen, 0);
  endtask

  task automatic grab(string req, logic [15:0] t, bit stall);
    int wait_n = 0, i = 0, err_i = -1, act = 0, expv = 0;
    @(negedge clk);
    while (!tx_valid && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    t_seen = cyc;
    if (!tx_valid) begin
      check(0, req, "no frame", 0, 1);
      return;
    end
    while (i < 60) begin
      tx_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (err_i < 0 && (!tx_valid || tx_data !== exp_byte(i, station_mac, t) || tx_last !== (i == 59))) begin
        err_i = i;
        act = {tx_valid, tx_last, tx_data};
        expv = {1'b1, i == 59, exp_byte(i, station_mac, t)};
      end
      @(posedge clk);
      if (tx_ready) i++;
      @(negedge clk);
    end
    tx_ready = 1;
    check(err_i < 0, req, $sformatf("frame byte %0d", err_i), act, expv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    check(tx_valid === 1'b0, "R1", "valid in reset", tx_valid, 0);
    rst_n = 1; gen_en = 1;
    @(negedge clk);
    check(tx_valid === 1'b0, "R1", "valid after reset", tx_valid, 0);

    fill_lvl = 99; quiet(20, "R5 below high mark");
    fill_lvl = 100; grab("R2 R3 xoff at high mark", pause_time, 0);
    quiet(20, "R2 single xoff");
    fill_lvl = 50; quiet(20, "R5 between marks");
    fill_lvl = 40; quiet(20, "R4 at low mark");
    fill_lvl = 39; grab("R4 xon", 16'h0, 0);
    fill_lvl = 10; quiet(20, "R4 no xon unpaused");

    gen_en = 0; fill_lvl = 500; quiet(30, "R9 disabled");
    fill_lvl = 10; @(negedge clk); gen_en = 1;

    for (int k = 0; k < 6; k++) begin
      station_mac = 48'h010203040506 * (k + 3) + 48'h111111 * k;
      pause_time  = 16'h0100 * k + 16'h0037 * (k + 1);
      hi_mark = 13'd200 + 13'd97 * k;
      lo_mark = 13'd20 + 13'd11 * k;
      fill_lvl = hi_mark + 13'(k); grab("R3 R7 sweep xoff", pause_time, k[0]);
      fill_lvl = lo_mark - 1;      grab("R3 R7 sweep xon", 16'h0, k[0]);
    end

    hi_mark = 100; lo_mark = 40; pause_time = 16'h00F0; refresh_thr = 20;
    fill_lvl = 120; grab("R6 first xoff", pause_time, 0);
    t0 = t_seen;
    pause_time = 16'h0ABC;
    grab("R6 R10 refresh xoff", 16'h0ABC, 0);
    check(t_seen - t0 == 20*S + 2, "R6", "refresh spacing", t_seen - t0, 20*S + 2);
    refresh_thr = 0;
    fill_lvl = 10; grab("R6 xon after refresh", 16'h0, 0);
    quiet(120, "R6 disabled refresh");

    tx_ready = 0; fill_lvl = 150;
    repeat (6) @(negedge clk);
    fill_lvl = 10;
    repeat (6) @(negedge clk);
    grab("R8 stalled xoff", pause_time, 0);
    grab("R8 queued xon", 16'h0, 0);

    tx_ready = 0; fill_lvl = 150;
    repeat (6) @(negedge clk);
    fill_lvl = 10;
    repeat (4) @(negedge clk);
    fill_lvl = 150;
    repeat (4) @(negedge clk);
    grab("R8 stalled xoff 2", pause_time, 0);
    grab("R8 xoff replaced xon", pause_time, 0);
    fill_lvl = 10; grab("R8 final xon", 16'h0, 0);
    quiet(30, "R8 nothing extra");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule